// File: doc/BRIEF.md
# ECC Error Log Capture Unit

This block sits next to a memory controller's read path. It keeps a record of the first memory read that reported an ECC error. Each read that fails the check raises one of two strobes: one for a correctable error, one for an uncorrectable error. Alongside the strobe come the location of the read (bank, rank, chunk index, column and row), the 8-bit syndrome and a poison flag. The block packs the record into two 32-bit read-only log words and keeps two sticky status bits, one for each error class.

Capture is asymmetric. A stored correctable error blocks later correctable errors, but an uncorrectable error replaces it. A stored uncorrectable error freezes the whole record until it is released. An external error-status register releases each status bit with a clear pulse for that class. The logged fields keep their values after a clear and are replaced only by the next capture. Every register returns to zero on the power-good reset.

Top module: `ecc_err_logger`

## Requirements
- R1: `log_word0` holds the bank in bits 31:29, the rank in bits 28:27, the chunk in bits 26:24 and the syndrome in bits 23:16. Bits 15:2 read as zero. Bit 1 mirrors `sts_uncorr` and bit 0 mirrors `sts_corr`.
- R2: `log_word1` holds the column in bits 31:16 and the row in bits 15:0.
- R3: A `ce_hit` pulse with both status bits clear sets `sts_corr` and captures all fields. The new values are readable on the cycle after the edge.
- R4: While `sts_corr` is set, a `ce_hit` pulse changes neither the fields nor the status bits.
- R5: A `ue_hit` pulse while `sts_uncorr` is clear sets `sts_uncorr` and captures all fields, including over a stored correctable record.
- R6: While `sts_uncorr` is set, no error pulse of either class changes any logged field.
- R7: When `err_poison` is high on a captured error, the stored syndrome is 8'hFF and `err_synd` is ignored.
- R8: `pgood_n` low drives both log words and both status bits to zero.
- R9: `clr_corr` clears `sts_corr` and `clr_uncorr` clears `sts_uncorr`. A clear leaves the logged fields unchanged.
- R10: When `ce_hit` and `ue_hit` arrive in the same cycle, only the uncorrectable error counts. `sts_uncorr` is set and `sts_corr` keeps its value.
- R11: When a clear pulse and an error pulse arrive in the same cycle, the clear takes effect first, so the error is captured if the cleared state allows it.
- R12: Clearing `sts_corr` while `sts_uncorr` stays set keeps the fields locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pgood_n | input | 1 | Power-good reset, active low, asynchronous |
| ce_hit | input | 1 | Correctable error on this read |
| ue_hit | input | 1 | Uncorrectable error on this read |
| err_bank | input | 3 | Bank address of the read |
| err_rank | input | 2 | Rank of the read |
| err_chunk | input | 3 | Chunk index within the burst |
| err_synd | input | 8 | Computed syndrome |
| err_poison | input | 1 | Error caused by poisoned data |
| err_col | input | 16 | DRAM column address |
| err_row | input | 16 | DRAM row address |
| clr_corr | input | 1 | Clear pulse for the correctable status |
| clr_uncorr | input | 1 | Clear pulse for the uncorrectable status |
| log_word0 | output | 32 | Packed bank, rank, chunk, syndrome and status |
| log_word1 | output | 32 | Packed column and row |
| sts_corr | output | 1 | Sticky correctable status |
| sts_uncorr | output | 1 | Sticky uncorrectable status |

## Verification
The bench drives the lock transitions in turn: correctable after correctable, uncorrectable over correctable, anything over uncorrectable, and a correctable clear while the uncorrectable bit stays set. A design that gets the lock wrong shows a changed row, column or syndrome in a log word that should have stayed frozen. Same-cycle collisions are also covered: both error classes at once, and a clear together with a new error. Getting the first wrong captures the wrong class, and getting the second wrong loses the error. Poisoned captures must show 8'hFF, and a long random run at the end compares both words against a behavioural model on every cycle.

// File: rtl/ecc_err_logger.sv
module ecc_err_logger (
  input  logic        clk,
  input  logic        pgood_n,
  input  logic        ce_hit,
  input  logic        ue_hit,
  input  logic [2:0]  err_bank,
  input  logic [1:0]  err_rank,
  input  logic [2:0]  err_chunk,
  input  logic [7:0]  err_synd,
  input  logic        err_poison,
  input  logic [15:0] err_col,
  input  logic [15:0] err_row,
  input  logic        clr_corr,
  input  logic        clr_uncorr,
  output logic [31:0] log_word0,
  output logic [31:0] log_word1,
  output logic        sts_corr,
  output logic        sts_uncorr
);
  localparam logic [7:0] POISON_SYND = 8'hFF;

  logic [2:0]  bank_q;
  logic [1:0]  rank_q;
  logic [2:0]  chunk_q;
  logic [7:0]  synd_q;
  logic [15:0] col_q, row_q;

  // status after this cycle's clear pulses
  logic ce_keep, ue_keep, take_ue, take_ce, capture;
  assign ce_keep = sts_corr & ~clr_corr;
  assign ue_keep = sts_uncorr & ~clr_uncorr;
  assign take_ue = ue_hit & ~ue_keep;
  assign take_ce = ce_hit & ~ue_hit & ~ue_keep & ~ce_keep;
  assign capture = take_ue | take_ce;

  always_ff @(posedge clk or negedge pgood_n) begin
    if (!pgood_n) begin
      sts_corr   <= 1'b0;
      sts_uncorr <= 1'b0;
      bank_q     <= '0;
      rank_q     <= '0;
      chunk_q    <= '0;
      synd_q     <= '0;
      col_q      <= '0;
      row_q      <= '0;
    end else begin
      sts_corr   <= ce_keep | take_ce;
      sts_uncorr <= ue_keep | take_ue;
      if (capture) begin
        bank_q  <= err_bank;
        rank_q  <= err_rank;
        chunk_q <= err_chunk;
        synd_q  <= err_poison ? POISON_SYND : err_synd;
        col_q   <= err_col;
        row_q   <= err_row;
      end
    end
  end

  assign log_word0 = {bank_q, rank_q, chunk_q, synd_q, 14'd0, sts_uncorr, sts_corr};
  assign log_word1 = {col_q, row_q};
endmodule

module ecc_err_logger_chk (
  input logic        clk,
  input logic        pgood_n,
  input logic        ce_hit,
  input logic        ue_hit,
  input logic        err_poison,
  input logic        clr_corr,
  input logic        clr_uncorr,
  input logic [31:0] log_word0,
  input logic [31:0] log_word1,
  input logic        sts_corr,
  input logic        sts_uncorr
);
  p_ue_lock_r6: assert property (@(posedge clk) disable iff (!pgood_n)
    (sts_uncorr && !clr_uncorr) |=> ($stable(log_word1) && $stable(log_word0[31:16])));

  p_ce_lock_r4: assert property (@(posedge clk) disable iff (!pgood_n)
    (sts_corr && !clr_corr && !ue_hit) |=> ($stable(log_word1) && $stable(log_word0[31:16])));

  p_ue_sets_r5: assert property (@(posedge clk) disable iff (!pgood_n)
    ue_hit |=> sts_uncorr);

  p_ce_sets_r3: assert property (@(posedge clk) disable iff (!pgood_n)
    (ce_hit && !ue_hit && !(sts_uncorr && !clr_uncorr)) |=> sts_corr);

  p_clear_r9: assert property (@(posedge clk) disable iff (!pgood_n)
    (clr_corr && !ce_hit) |=> !sts_corr);

  p_poison_r7: assert property (@(posedge clk) disable iff (!pgood_n)
    (ue_hit && err_poison && !(sts_uncorr && !clr_uncorr)) |=> (log_word0[23:16] == 8'hFF));

  p_rsvd_r1: assert property (@(posedge clk) disable iff (!pgood_n)
    log_word0[15:2] == 14'd0);
endmodule

bind ecc_err_logger ecc_err_logger_chk u_chk (.*);

// File: tb/ecc_err_logger_tb_top.sv
module ecc_err_logger_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic pgood_n, ce_hit, ue_hit, err_poison, clr_corr, clr_uncorr;
  logic [2:0] err_bank, err_chunk;
  logic [1:0] err_rank;
  logic [7:0] err_synd;
  logic [15:0] err_col, err_row;
  logic [31:0] log_word0, log_word1;
  logic sts_corr, sts_uncorr;

  ecc_err_logger dut_i (.*);

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  // behavioural reference state
  int m_bank, m_rank, m_chunk, m_synd, m_col, m_row;
  bit m_ce, m_ue;

  function automatic logic [31:0] exp0();
    return {m_bank[2:0], m_rank[1:0], m_chunk[2:0], m_synd[7:0], 14'd0, m_ue, m_ce};
  endfunction
  function automatic logic [31:0] exp1();
    return {m_col[15:0], m_row[15:0]};
  endfunction

  task automatic model_step();
    bit grab;
    if (!pgood_n) begin
      m_ce = 0; m_ue = 0;
      m_bank = 0; m_rank = 0; m_chunk = 0; m_synd = 0; m_col = 0; m_row = 0;
      return;
    end
    if (clr_corr) m_ce = 0;
    if (clr_uncorr) m_ue = 0;
    grab = 0;
    if (m_ue) grab = 0;
    else if (ue_hit) begin m_ue = 1; grab = 1; end
    else if (ce_hit && !m_ce) begin m_ce = 1; grab = 1; end
    if (grab) begin
      m_bank = err_bank; m_rank = err_rank; m_chunk = err_chunk;
      m_synd = err_poison ? 255 : int'(err_synd);
      m_col = err_col; m_row = err_row;
    end
  endtask

  task automatic compare(input string tag);
    n_cmp++;
    if (log_word0 !== exp0() || log_word1 !== exp1() ||
        sts_corr !== m_ce || sts_uncorr !== m_ue) begin
      n_bad++;
      $display("FAIL %s: w0=%h w1=%h ce=%b ue=%b expected w0=%h w1=%h ce=%b ue=%b",
               tag, log_word0, log_word1, sts_corr, sts_uncorr, exp0(), exp1(), m_ce, m_ue);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
    ce_hit = 0; ue_hit = 0; clr_corr = 0; clr_uncorr = 0; err_poison = 0;
  endtask

  task automatic fields(input int b, input int r, input int c, input int s,
                        input int col, input int row);
    err_bank = b[2:0]; err_rank = r[1:0]; err_chunk = c[2:0];
    err_synd = s[7:0]; err_col = col[15:0]; err_row = row[15:0];
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    pgood_n = 0; ce_hit = 0; ue_hit = 0; err_poison = 0; clr_corr = 0; clr_uncorr = 0;
    fields(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    tick("R8 reset");
    tick("R8 reset");
    pgood_n = 1;
    tick("R8 idle after reset");

    fields(5, 2, 6, 8'h3C, 16'hA1B2, 16'hC3D4); ce_hit = 1;
    tick("R3 correctable capture");
    if (log_word0 !== 32'hB63C_0001) begin
      n_bad++; $display("FAIL R1 layout: w0=%h expected b63c0001", log_word0);
    end
    n_cmp++;
    if (log_word1 !== 32'hA1B2_C3D4) begin
      n_bad++; $display("FAIL R2 layout: w1=%h expected a1b2c3d4", log_word1);
    end
    n_cmp++;

    fields(1, 1, 1, 8'h11, 16'h1111, 16'h2222); ce_hit = 1;
    tick("R4 correctable blocked");
    tick("R4 hold");

    fields(3, 3, 2, 8'h55, 16'h7777, 16'h8888); ue_hit = 1; err_poison = 1;
    tick("R5 uncorrectable overrides, R7 poison");
    if (log_word0[23:16] !== 8'hFF) begin
      n_bad++; $display("FAIL R7 poison: synd=%h expected ff", log_word0[23:16]);
    end
    n_cmp++;

    fields(7, 0, 7, 8'h99, 16'hDEAD, 16'hBEEF); ue_hit = 1;
    tick("R6 uncorrectable locked");
    ce_hit = 1;
    tick("R6 correctable vs locked");

    clr_corr = 1;
    tick("R12 clear correctable, fields stay locked");
    fields(2, 1, 4, 8'h42, 16'h0F0F, 16'hF0F0); ue_hit = 1;
    tick("R12 still locked");

    clr_uncorr = 1;
    tick("R9 clear keeps fields");

    fields(4, 0, 3, 8'h21, 16'h1234, 16'h5678); ce_hit = 1;
    tick("R3 capture after clear");
    fields(6, 3, 5, 8'h7E, 16'h9ABC, 16'hDEF0); ce_hit = 1; clr_corr = 1;
    tick("R11 clear and error same cycle");
    fields(1, 2, 1, 8'h0A, 16'h4444, 16'h5555); ue_hit = 1; clr_uncorr = 1; clr_corr = 1;
    tick("R11 clear and uncorrectable same cycle");
    clr_uncorr = 1;
    tick("R9 clear uncorrectable");

    fields(2, 2, 2, 8'h66, 16'h3333, 16'h6666); ce_hit = 1; ue_hit = 1;
    tick("R10 both classes, uncorrectable wins");
    if (sts_corr !== 1'b0 || sts_uncorr !== 1'b1) begin
      n_bad++; $display("FAIL R10 status: ce=%b ue=%b expected ce=0 ue=1", sts_corr, sts_uncorr);
    end
    n_cmp++;

    fields(5, 1, 0, 8'hC0, 16'h0001, 16'h0002); ce_hit = 1; ue_hit = 1; err_poison = 1;
    clr_uncorr = 1;
    tick("R7 poison with R11 clear");

    pgood_n = 0;
    tick("R8 reset while logged");
    pgood_n = 1;
    tick("R8 after reset");

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      fields($urandom % 8, $urandom % 4, $urandom % 8, $urandom % 256,
             $urandom % 65536, $urandom % 65536);
      ce_hit = (r % 4) == 0;
      ue_hit = (r % 11) == 0;
      err_poison = (r % 7) == 0;
      clr_corr = (r % 13) == 0;
      clr_uncorr = (r % 17) == 0;
      pgood_n = (r % 997) != 0;
      tick("R1 R2 random run");
    end
    pgood_n = 1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule